// File: doc/BRIEF.md
# TLB Replacement State Tracker

This block holds the replacement bookkeeping for a small translation cache pair: a four-way fully associative instruction TLB and a 64-entry unified TLB. The state lives in one 32-bit MMU control word. Its top six bits record the relative age of the four instruction-TLB ways as six pairwise-order bits. A six-bit rotating counter in the middle of the word points at the unified-TLB slot that the next software load will fill.

The surrounding MMU reports instruction-TLB hits with a way index. It raises a refill strobe when a way is overwritten from the unified TLB, and an access strobe on every unified-TLB lookup or array access. The block continuously decodes which instruction-TLB way should be evicted next. It also presents the counter and the whole control word. Software may overwrite the control word at any time, and that write wins over any hardware update in the same cycle.

Top module: `tlb_repl_tracker`

## Requirements
- R1: After reset the control word reads 0x00000000, the counter reads 0, the victim is way 3 and the no-match flag is low.
- R2: When `sw_we` is high, the control word takes `sw_wdata` on the next clock edge. Any hit, refill or access in that same cycle is discarded.
- R3: A hit on way k rewrites the top byte (bits 31:24) as (byte AND A_k) OR O_k. The AND masks A are 0x1F, 0xE7, 0xFB and 0xFF for ways 0 to 3. The OR masks O are 0x00, 0x80, 0x50 and 0x2C.
- R4: The victim is picked by the first matching test on the word:
  - way 0 if bits 31,30,29 are 1,1,1;
  - else way 1 if bits 31,28,27 are 0,1,1;
  - else way 2 if bits 30,28,26 are 0,0,1;
  - else way 3 if bits 29,27,26 are 0,0,0.
- R5: If none of the four tests matches, `victim_err` is high and `victim_idx` is 0.
- R6: A refill applies the R3 update for the way that is the victim before the edge, making that way most recently used. When refill and hit arrive together, the refill is applied and the hit is dropped.
- R7: Each cycle with `utlb_access` high advances the counter in bits 15:10 by one. When the boundary in bits 23:18 is nonzero and the incremented value exceeds it, the counter becomes 0.
- R8: With a zero boundary, the counter wraps from 63 to 0.
- R9: Without a software write, bits 25:16 and 9:0 never change. A hit or refill leaves the counter untouched, and an access leaves bits 31:26 untouched.
- R10: `ctr_value` always equals bits 15:10 of `ctl_reg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hit_valid | input | 1 | Instruction-TLB hit strobe |
| hit_idx | input | 2 | Way that hit |
| refill | input | 1 | Victim way is being refilled from the unified TLB |
| utlb_access | input | 1 | Unified-TLB access strobe |
| sw_we | input | 1 | Software write of the control word |
| sw_wdata | input | 32 | Value written by software |
| ctl_reg | output | 32 | Current control word |
| victim_idx | output | 2 | Instruction-TLB way to evict next |
| victim_err | output | 1 | No victim test matched |
| ctr_value | output | 6 | Unified-TLB replacement counter |

## Verification
The properties assume only that the strobes are clean after reset. Software values may be arbitrary, including age patterns that no sequence of hits can produce and counters already above the boundary. The most-recently-used and boundary properties are therefore guarded by the absence of a same-cycle software write. Under that guard the boundary they read is the one in force. The stimulus mixes hits, refills and accesses freely. It issues occasional writes that span zero and small boundaries, counters near the wrap point and inconsistent age bytes, so that every guarded path is reached.

// File: rtl/tlb_repl_pkg.sv
package tlb_repl_pkg;
  localparam int CTL_W    = 32;
  localparam int WAYS     = 4;
  localparam int IDX_W    = $clog2(WAYS);
  localparam int AGE_W    = 8;
  localparam int AGE_LSB  = CTL_W - AGE_W;
  localparam int CTR_W    = 6;
  localparam int CTR_LSB  = 10;
  localparam int BND_LSB  = 18;
  localparam int CTR_MAX  = (1 << CTR_W) - 1;

  typedef logic [AGE_W-1:0] age_t;
  typedef logic [CTR_W-1:0] ctr_t;
  typedef logic [IDX_W-1:0] way_t;

  function automatic age_t touch_and(way_t w);
    case (w)
      2'd0:    return 8'h1F;
      2'd1:    return 8'hE7;
      2'd2:    return 8'hFB;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic age_t touch_or(way_t w);
    case (w)
      2'd0:    return 8'h00;
      2'd1:    return 8'h80;
      2'd2:    return 8'h50;
      default: return 8'h2C;
    endcase
  endfunction

  function automatic age_t sel_mask(int w);
    case (w)
      0:       return 8'hE0;
      1:       return 8'h98;
      2:       return 8'h54;
      default: return 8'h2C;
    endcase
  endfunction

  function automatic age_t sel_val(int w);
    case (w)
      0:       return 8'hE0;
      1:       return 8'h18;
      2:       return 8'h04;
      default: return 8'h00;
    endcase
  endfunction

  function automatic ctr_t ctr_advance(ctr_t c, ctr_t bnd);
    logic [CTR_W:0] inc;
    inc = {1'b0, c} + 1'b1;
    if (((bnd != '0) && (inc > {1'b0, bnd})) || (inc > (CTR_W+1)'(CTR_MAX)))
      return '0;
    return inc[CTR_W-1:0];
  endfunction
endpackage

// File: rtl/tlb_age_touch.sv
module tlb_age_touch
  import tlb_repl_pkg::*;
(
  input  age_t age_in,
  input  way_t way,
  output age_t age_out
);
  assign age_out = (age_in & touch_and(way)) | touch_or(way);
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel
  import tlb_repl_pkg::*;
(
  input  age_t         age,
  output logic [WAYS-1:0] way_match,
  output way_t         victim,
  output logic         none
);
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign way_match[g] = (age & sel_mask(g)) == sel_val(g);
  end

  always_comb begin
    victim = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (way_match[i]) victim = way_t'(i);
    end
  end

  assign none = ~|way_match;
endmodule

// File: rtl/tlb_ctr_step.sv
module tlb_ctr_step
  import tlb_repl_pkg::*;
(
  input  ctr_t ctr,
  input  ctr_t bnd,
  output ctr_t ctr_next,
  output logic wrapped
);
  assign ctr_next = ctr_advance(ctr, bnd);
  assign wrapped  = (ctr_next == '0);
endmodule

// File: rtl/tlb_repl_tracker.sv
module tlb_repl_tracker
  import tlb_repl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_valid,
  input  logic [IDX_W-1:0]  hit_idx,
  input  logic              refill,
  input  logic              utlb_access,
  input  logic              sw_we,
  input  logic [CTL_W-1:0]  sw_wdata,
  output logic [CTL_W-1:0]  ctl_reg,
  output logic [IDX_W-1:0]  victim_idx,
  output logic              victim_err,
  output logic [CTR_W-1:0]  ctr_value
);
  logic [CTL_W-1:0] ctl_q, ctl_d;
  age_t             age_now, age_touched;
  logic [WAYS-1:0]  way_match;
  way_t             victim_w, touch_way;
  logic             touch_en;
  ctr_t             ctr_now, bnd_now, ctr_nxt;
  logic             ctr_wrapped;

  assign age_now   = ctl_q[CTL_W-1 -: AGE_W];
  assign ctr_now   = ctl_q[CTR_LSB +: CTR_W];
  assign bnd_now   = ctl_q[BND_LSB +: CTR_W];

  tlb_victim_sel u_sel (
    .age       (age_now),
    .way_match (way_match),
    .victim    (victim_w),
    .none      (victim_err)
  );

  assign touch_en  = refill | hit_valid;
  assign touch_way = refill ? victim_w : hit_idx;

  tlb_age_touch u_touch (
    .age_in  (age_now),
    .way     (touch_way),
    .age_out (age_touched)
  );

  tlb_ctr_step u_ctr (
    .ctr      (ctr_now),
    .bnd      (bnd_now),
    .ctr_next (ctr_nxt),
    .wrapped  (ctr_wrapped)
  );

  always_comb begin
    ctl_d = ctl_q;
    if (sw_we) begin
      ctl_d = sw_wdata;
    end else begin
      if (touch_en)    ctl_d[CTL_W-1 -: AGE_W]  = age_touched;
      if (utlb_access) ctl_d[CTR_LSB +: CTR_W] = ctr_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign ctl_reg    = ctl_q;
  assign victim_idx = victim_w;
  assign ctr_value  = ctr_now;
endmodule

// File: rtl/tlb_repl_tracker_chk.sv
module tlb_repl_tracker_chk
  import tlb_repl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              hit_valid,
  input logic [IDX_W-1:0]  hit_idx,
  input logic              refill,
  input logic              utlb_access,
  input logic              sw_we,
  input logic [CTL_W-1:0]  sw_wdata,
  input logic [CTL_W-1:0]  ctl_reg,
  input logic [IDX_W-1:0]  victim_idx,
  input logic              victim_err,
  input logic [CTR_W-1:0]  ctr_value,
  input logic              ctr_wrapped
);
  localparam logic [CTL_W-1:0] KEEP = 32'h03FF_03FF;

  // R2
  sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> ctl_reg == $past(sw_wdata));

  // R5
  no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    victim_err |-> victim_idx == '0);

  // R3
  mru_not_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && !refill && !sw_we) |=> (victim_err || victim_idx != $past(hit_idx)));

  // R6
  refill_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refill && !sw_we && !victim_err) |=> (victim_err || victim_idx != $past(victim_idx)));

  // R7
  ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (utlb_access && !sw_we) |=> (ctr_value == '0 || ctr_value == $past(ctr_value) + 1'b1));

  // R7
  ctr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (utlb_access && !sw_we && ctl_reg[BND_LSB +: CTR_W] != '0)
      |=> ctr_value <= ctl_reg[BND_LSB +: CTR_W]);

  // R7
  ctr_wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (utlb_access && !sw_we && ctr_wrapped) |=> ctr_value == '0);

  // R9
  ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!utlb_access && !sw_we) |=> $stable(ctr_value));

  // R9
  keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_we |=> (ctl_reg & KEEP) == ($past(ctl_reg) & KEEP));

  // R9
  age_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_valid && !refill && !sw_we) |=> $stable(ctl_reg[CTL_W-1 -: AGE_W]));

  // R10
  ctr_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_value == ctl_reg[CTR_LSB +: CTR_W]);
endmodule

bind tlb_repl_tracker tlb_repl_tracker_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hit_valid   (hit_valid),
  .hit_idx     (hit_idx),
  .refill      (refill),
  .utlb_access (utlb_access),
  .sw_we       (sw_we),
  .sw_wdata    (sw_wdata),
  .ctl_reg     (ctl_reg),
  .victim_idx  (victim_idx),
  .victim_err  (victim_err),
  .ctr_value   (ctr_value),
  .ctr_wrapped (ctr_wrapped)
);

// File: tb/tlb_repl_tracker_tb.sv
`timescale 1ns/1ps
module tlb_repl_tracker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hit_valid = 1'b0;
  logic [1:0]  hit_idx = '0;
  logic        refill = 1'b0;
  logic        utlb_access = 1'b0;
  logic        sw_we = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] ctl_reg;
  logic [1:0]  victim_idx;
  logic        victim_err;
  logic [5:0]  ctr_value;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;
  logic [31:0] model = '0;

  always #2.5 clk = ~clk;

  tlb_repl_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_idx(hit_idx),
    .refill(refill), .utlb_access(utlb_access), .sw_we(sw_we),
    .sw_wdata(sw_wdata), .ctl_reg(ctl_reg), .victim_idx(victim_idx),
    .victim_err(victim_err), .ctr_value(ctr_value)
  );

  // Age byte update, written bit by bit from the R3 masks
  function automatic logic [7:0] b_touch(logic [7:0] a, logic [1:0] w);
    logic [7:0] r = a;
    case (w)
      2'd0: begin r[7] = 0; r[6] = 0; r[5] = 0; end
      2'd1: begin r[4] = 0; r[3] = 0; r[7] = 1; end
      2'd2: begin r[2] = 0; r[6] = 1; r[4] = 1; end
      2'd3: begin r[5] = 1; r[3] = 1; r[2] = 1; end
    endcase
    return r;
  endfunction

  // {err, way} from the R4/R5 bit tests
  function automatic logic [2:0] b_victim(logic [31:0] c);
    if (c[31] && c[30] && c[29])        return 3'b0_00;
    if (!c[31] && c[28] && c[27])       return 3'b0_01;
    if (!c[30] && !c[28] && c[26])      return 3'b0_10;
    if (!c[29] && !c[27] && !c[26])     return 3'b0_11;
    return 3'b1_00;
  endfunction

  function automatic logic [5:0] b_ctr(logic [5:0] c, logic [5:0] b);
    int n = int'(c) + 1;
    if (n > 63 || (b != 0 && n > int'(b))) return 6'd0;
    return 6'(n);
  endfunction

  function automatic logic [31:0] b_next(logic [31:0] c, bit hv, logic [1:0] hi,
                                         bit rf, bit ua, bit we, logic [31:0] wd);
    logic [31:0] r = c;
    logic [2:0]  v = b_victim(c);
    if (we) return wd;
    if (rf)      r[31:24] = b_touch(c[31:24], v[1:0]);
    else if (hv) r[31:24] = b_touch(c[31:24], hi);
    if (ua)      r[15:10] = b_ctr(c[15:10], c[23:18]);
    return r;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string rreg, string rvic);
    logic [2:0] v = b_victim(model);
    chk(rreg, "ctl_reg", ctl_reg, model);
    chk(rvic, "victim_idx", 32'(victim_idx), 32'(v[1:0]));
    chk("R5", "victim_err", 32'(victim_err), 32'(v[2]));
    chk("R10", "ctr_value", 32'(ctr_value), 32'(model[15:10]));
  endtask

  // Called at a negedge: drive, take one edge, compare at the next negedge
  task automatic step(bit hv, logic [1:0] hi, bit rf, bit ua, bit we, logic [31:0] wd);
    hit_valid = hv; hit_idx = hi; refill = rf; utlb_access = ua;
    sw_we = we; sw_wdata = wd;
    model = b_next(model, hv, hi, rf, ua, we, wd);
    @(negedge clk);
    hit_valid = 0; refill = 0; utlb_access = 0; sw_we = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "ctl_reg", ctl_reg, 32'h0);
    chk("R1", "victim_idx", 32'(victim_idx), 32'd3);
    chk("R1", "victim_err", 32'(victim_err), 32'd0);
    chk("R1", "ctr_value", 32'(ctr_value), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 boundary 3: counter runs 1,2,3,0
    step(0, 0, 0, 0, 1, 32'h000C_0000);
    chk("R2", "ctl_reg", ctl_reg, 32'h000C_0000);
    for (int i = 1; i <= 4; i++) begin
      step(0, 0, 0, 1, 0, 0);
      chk("R7", "ctr_value", 32'(ctr_value), 32'(i % 4));
    end

    // R8 zero boundary: 62 -> 63 -> 0
    step(0, 0, 0, 0, 1, 32'h0000_F800);
    step(0, 0, 0, 1, 0, 0);
    chk("R8", "ctr_value", 32'(ctr_value), 32'd63);
    step(0, 0, 0, 1, 0, 0);
    chk("R8", "ctr_value", 32'(ctr_value), 32'd0);

    // R3 hit on way 3 from zero age gives 0x2C, victim 2
    step(0, 0, 0, 0, 1, 32'h0);
    step(1, 2'd3, 0, 0, 0, 0);
    chk("R3", "age byte", 32'(ctl_reg[31:24]), 32'h2C);
    chk("R4", "victim_idx", 32'(victim_idx), 32'd2);

    // R3/R9 hit on way 1 keeps other bits
    step(0, 0, 0, 0, 1, 32'h03FF_03FF);
    step(1, 2'd1, 0, 0, 0, 0);
    chk("R3", "ctl_reg", ctl_reg, 32'h83FF_03FF);
    chk("R9", "ctr_value", 32'(ctr_value), 32'd0);

    // R5 inconsistent age pattern
    step(0, 0, 0, 0, 1, 32'h2000_0000);
    chk("R5", "victim_err", 32'(victim_err), 32'd1);
    chk("R5", "victim_idx", 32'(victim_idx), 32'd0);

    // R6 refill: 3 -> byte 0x2C, victim 2 -> byte 0x78, victim 1
    step(0, 0, 0, 0, 1, 32'h0);
    step(0, 0, 1, 0, 0, 0);
    chk("R6", "age byte", 32'(ctl_reg[31:24]), 32'h2C);
    step(0, 0, 1, 0, 0, 0);
    chk("R6", "age byte", 32'(ctl_reg[31:24]), 32'h78);
    chk("R6", "victim_idx", 32'(victim_idx), 32'd1);
    // R6 refill beats same-cycle hit on way 0 (victim 1: 0x78 & E7 | 80 = 0xE0)
    step(1, 2'd0, 1, 0, 0, 0);
    chk("R6", "age byte", 32'(ctl_reg[31:24]), 32'hE0);

    // R2 software write overrides hit, refill and access
    step(1, 2'd2, 1, 1, 1, 32'hA5A5_5A5A);
    chk("R2", "ctl_reg", ctl_reg, 32'hA5A5_5A5A);

    // Random phase
    for (int k = 0; k < 3000; k++) begin
      bit hv = ($urandom % 2) == 0;
      bit rf = ($urandom % 5) == 0;
      bit ua = ($urandom % 2) == 0;
      bit we = ($urandom % 16) == 0;
      logic [31:0] wd = $urandom;
      logic [1:0]  hi = 2'($urandom);
      if ($urandom % 2 == 0) wd[23:18] = 6'($urandom % 5);
      if ($urandom % 3 == 0) wd[15:10] = 6'd60 + 6'($urandom % 4);
      step(hv, hi, rf, ua, we, wd);
      chk_all("R9", "R4");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule